// File: doc/BRIEF.md
# Latched Status and Interrupt Controller

This block collects alarm signals for a line framer and holds them for a host processor. Three 8-bit status registers latch 24 input pins. Each register has its own 8-bit interrupt enable register. A parameter assigns every input bit one of three behaviours:
- **Edge-latched event:** latches on a rising edge of the input.
- **Level condition:** keeps latching while the input stays high.
- **Two-edge condition:** behaves like a level condition and also latches when the input falls, so it interrupts when the condition starts and when it ends.

A fault and its recovery may arrive on two separate pins. In that case the recovery pin is an ordinary event bit.

The host reads a status register in two steps. First it writes a byte to that register. Each selected position (a 1 in the written byte) copies its latch into the read snapshot and clears the latch. Unselected positions keep their old snapshot value, and their latch is not touched. The following read returns the snapshot. A summary register has one bit per status register and shows which registers hold an enabled pending bit. The interrupt pin is the registered OR of the summary bits.

Top module: `statIrqTop`

## Requirements
- R1: After reset, every status snapshot, enable register and the summary read 0, and `irqOut` is 0.
- R2: An event bit latches on a 0-to-1 input transition. It stays latched until a status write selects it. After that clear it stays 0 while the input remains high, and it latches again only on a new rising edge. In the default map, register 0 bits 7..4 are event bits.
- R3: A level condition bit that is cleared while its input is still high latches again at the same edge. It reads 1 on every write-read until the input has been low across one clearing write. In the default map, register 0 bits 3..0 and register 1 bit 3 are level conditions.
- R4: For a status write, a 1 in byte position b loads the latch of bit b into the snapshot and clears the latch. A 0 keeps the old snapshot bit and leaves the latch unchanged.
- R5: A two-edge condition bit also latches on a 1-to-0 input transition, even when a clearing write lands on that same edge. In the default map these are register 1 bits 1 and 2 and register 2 bit 7.
- R6: A latched bit contributes to the summary and the interrupt only while its enable bit is 1.
- R7: Summary bit r (address 6) is 1 when status register r has an enabled latched bit. Writes to address 6 have no effect.
- R8: An input transition that arrives on the same edge as a clearing write stays latched and is returned by the next write-read.
- R9: `irqOut` is active high. It equals the OR of the summary bits one clock earlier.
- R10: Status registers 0 to 2 are read at addresses 0 to 2. Enable registers 0 to 2 are at addresses 3 to 5 and read back the value written. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sigIn | input | 24 | Alarm inputs; bit 8*r+b feeds status register r bit b |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data (status select byte or enable value) |
| busRdata | output | 8 | Read data for `busAddr`, combinational from held registers |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The timing of each result is fixed:
- An input change driven before an edge is in the latch after that edge and in the summary right away.
- `irqOut` follows one edge later, so it rises two edges after the input change.
- A status write updates the snapshot at its own edge. Read data is a combinational view of held registers, so it is valid at the falling edge that follows.

The bench drives inputs and writes on falling edges and samples one falling edge after each expected update. Coincident cases put the input change and the write on the same falling edge, which places both on the same rising edge.

// File: rtl/statIrqPkg.sv
package statIrqPkg;
  localparam int NUM_STAT = 3;
  localparam int STAT_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_BITS = NUM_STAT * STAT_W;

  typedef enum logic [1:0] {
    KIND_EVENT  = 2'd0,
    KIND_COND   = 2'd1,
    KIND_DOUBLE = 2'd2
  } bitKind_e;

  typedef struct packed {
    logic [NUM_STAT-1:0] statWr;
    logic [NUM_STAT-1:0] maskWr;
    logic [STAT_W-1:0]   wrData;
    logic [ADDR_W-1:0]   rdSel;
  } busStrobes_t;

  // Default map: low nibble level conditions, high nibble events,
  // with two-edge conditions at reg1 bits 1..2 and reg2 bit 7.
  function automatic logic [2*NUM_BITS-1:0] defaultKinds();
    logic [2*NUM_BITS-1:0] k;
    k = '0;
    for (int r = 0; r < NUM_STAT; r++) begin
      for (int b = 0; b < STAT_W; b++) begin
        bitKind_e kb;
        if ((r == 1 && (b == 1 || b == 2)) || (r == 2 && b == 7)) kb = KIND_DOUBLE;
        else if (b < STAT_W / 2) kb = KIND_COND;
        else kb = KIND_EVENT;
        k[2*(r*STAT_W+b) +: 2] = kb;
      end
    end
    return k;
  endfunction
endpackage

// File: rtl/statIrqCtrl.sv
module statIrqCtrl
  import statIrqPkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [STAT_W-1:0] busWdata,
  output busStrobes_t       stb
);
  always_comb begin
    stb        = '0;
    stb.wrData = busWdata;
    stb.rdSel  = busAddr;
    for (int r = 0; r < NUM_STAT; r++) begin
      if (busWe && busAddr == ADDR_W'(r))            stb.statWr[r] = 1'b1;
      if (busWe && busAddr == ADDR_W'(NUM_STAT + r)) stb.maskWr[r] = 1'b1;
    end
  end
endmodule

// File: rtl/statIrqDatapath.sv
module statIrqDatapath
  import statIrqPkg::*;
#(
  parameter logic [2*NUM_BITS-1:0] KINDS = defaultKinds()
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] sigIn,
  input  busStrobes_t         stb,
  output logic [STAT_W-1:0]   rdData,
  output logic [NUM_STAT-1:0] summary,
  output logic                irq,
  output logic [NUM_BITS-1:0] pendVec,
  output logic [NUM_BITS-1:0] maskVec
);
  localparam int SUM_ADDR = 2 * NUM_STAT;

  logic [NUM_BITS-1:0] prevIn;
  logic [NUM_BITS-1:0] setNow;
  logic [NUM_BITS-1:0] clrNow;
  logic [NUM_BITS-1:0] snapVec;

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    localparam int REG_IDX = i / STAT_W;
    localparam int BIT_IDX = i % STAT_W;
    localparam bitKind_e KIND = bitKind_e'(KINDS[2*i +: 2]);
    if (KIND == KIND_EVENT) begin : g_evt
      assign setNow[i] = sigIn[i] & ~prevIn[i];
    end else if (KIND == KIND_COND) begin : g_cond
      assign setNow[i] = sigIn[i];
    end else begin : g_dbl
      // level while high, plus the cycle of the falling edge
      assign setNow[i] = sigIn[i] | prevIn[i];
    end
    assign clrNow[i] = stb.statWr[REG_IDX] & stb.wrData[BIT_IDX];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevIn  <= '0;
      pendVec <= '0;
      snapVec <= '0;
      maskVec <= '0;
      irq     <= 1'b0;
    end else begin
      prevIn  <= sigIn;
      pendVec <= setNow | (pendVec & ~clrNow);
      snapVec <= (clrNow & pendVec) | (~clrNow & snapVec);
      for (int r = 0; r < NUM_STAT; r++) begin
        if (stb.maskWr[r]) maskVec[r*STAT_W +: STAT_W] <= stb.wrData;
      end
      irq <= |summary;
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_STAT; r++) begin
      summary[r] = |(pendVec[r*STAT_W +: STAT_W] & maskVec[r*STAT_W +: STAT_W]);
    end
  end

  always_comb begin
    rdData = '0;
    for (int r = 0; r < NUM_STAT; r++) begin
      if (stb.rdSel == ADDR_W'(r))            rdData = snapVec[r*STAT_W +: STAT_W];
      if (stb.rdSel == ADDR_W'(NUM_STAT + r)) rdData = maskVec[r*STAT_W +: STAT_W];
    end
    if (stb.rdSel == ADDR_W'(SUM_ADDR)) rdData = STAT_W'(summary);
  end
endmodule

// File: rtl/statIrqTop.sv
module statIrqTop
  import statIrqPkg::*;
#(
  parameter logic [2*NUM_BITS-1:0] KINDS = defaultKinds()
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] sigIn,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [STAT_W-1:0]   busWdata,
  output logic [STAT_W-1:0]   busRdata,
  output logic                irqOut
);
  busStrobes_t         stb;
  logic [NUM_STAT-1:0] summary;
  logic [NUM_BITS-1:0] pendVec;
  logic [NUM_BITS-1:0] maskVec;

  statIrqCtrl u_ctrl (
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb)
  );

  statIrqDatapath #(.KINDS(KINDS)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .sigIn   (sigIn),
    .stb     (stb),
    .rdData  (busRdata),
    .summary (summary),
    .irq     (irqOut),
    .pendVec (pendVec),
    .maskVec (maskVec)
  );
endmodule

// File: rtl/statIrqChecker.sv
module statIrqChecker
  import statIrqPkg::*;
#(
  parameter logic [2*NUM_BITS-1:0] KINDS = defaultKinds()
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_BITS-1:0] sigIn,
  input logic                busWe,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [STAT_W-1:0]   busWdata,
  input logic [NUM_STAT-1:0] summary,
  input logic [NUM_BITS-1:0] pendVec,
  input logic [NUM_BITS-1:0] maskVec,
  input logic                irqOut
);
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irqOut == $past(|summary)));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> $past(|(pendVec & maskVec)));

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_chk
    localparam int REG_IDX = i / STAT_W;
    localparam int BIT_IDX = i % STAT_W;
    localparam bitKind_e KIND = bitKind_e'(KINDS[2*i +: 2]);

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pendVec[i] && !(busWe && busAddr == ADDR_W'(REG_IDX) && busWdata[BIT_IDX]))
      |=> pendVec[i]);

    if (KIND == KIND_EVENT) begin : g_evt
      // R8
      event_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sigIn[i]) |=> pendVec[i]);
    end else begin : g_lvl
      // R3
      cond_level_chk: assert property (@(posedge clk) disable iff (rst)
        sigIn[i] |=> pendVec[i]);
    end
  end
endmodule

bind statIrqTop statIrqChecker #(.KINDS(KINDS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sigIn    (sigIn),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .summary  (summary),
  .pendVec  (pendVec),
  .maskVec  (maskVec),
  .irqOut   (irqOut)
);

// File: tb/sim_statIrqTop.sv
`timescale 1ns/1ps
module sim_statIrqTop;
  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] sigIn;
  logic        busWe;
  logic [2:0]  busAddr;
  logic [7:0]  busWdata;
  logic [7:0]  busRdata;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  statIrqTop u0 (
    .clk(clk), .rst(rst), .sigIn(sigIn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rst = 1'b1; sigIn = '0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic writeSig(input logic [2:0] a, input logic [7:0] d, input logic [23:0] s);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d; sigIn = s;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    writeSig(a, d, sigIn);
  endtask

  task automatic expectReg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    busAddr = a;
    #0.5;
    check(tag, busRdata, exp);
  endtask

  task automatic testReset();
    resetDut();
    for (int a = 0; a < 7; a++) expectReg("R1 reset reg", 3'(a), 8'h00);
    check("R1 reset irq", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testEvent();
    resetDut();
    @(negedge clk); sigIn[4] = 1'b1;
    writeReg(0, 8'h10); expectReg("R2 event latched", 0, 8'h10);
    writeReg(0, 8'h10); expectReg("R2 no relatch while high", 0, 8'h00);
    @(negedge clk); sigIn[4] = 1'b0;
    @(negedge clk); sigIn[4] = 1'b1;
    writeReg(0, 8'h10); expectReg("R2 new edge relatches", 0, 8'h10);
  endtask

  task automatic testCondition();
    resetDut();
    @(negedge clk); sigIn[0] = 1'b1;
    writeReg(0, 8'h01); expectReg("R3 cond first read", 0, 8'h01);
    writeReg(0, 8'h01); expectReg("R3 cond still active", 0, 8'h01);
    @(negedge clk); sigIn[0] = 1'b0;
    writeReg(0, 8'h01); expectReg("R3 cond latched after drop", 0, 8'h01);
    writeReg(0, 8'h01); expectReg("R3 cond cleared", 0, 8'h00);
  endtask

  task automatic testSelect();
    resetDut();
    @(negedge clk); sigIn[5] = 1'b1;
    writeReg(0, 8'h20); expectReg("R4 single select", 0, 8'h20);
    @(negedge clk); sigIn[6] = 1'b1; sigIn[7] = 1'b1;
    writeReg(0, 8'h40); expectReg("R4 unselected held", 0, 8'h60);
    writeReg(0, 8'h80); expectReg("R4 latch untouched", 0, 8'hE0);
  endtask

  task automatic testDouble();
    logic [23:0] s;
    resetDut();
    @(negedge clk); sigIn[9] = 1'b1; sigIn[11] = 1'b1;
    s = sigIn; s[9] = 1'b0; s[11] = 1'b0;
    writeSig(1, 8'h0A, s);
    expectReg("R5 snapshot before fall", 1, 8'h0A);
    writeReg(1, 8'h0A); expectReg("R5 fall latches two-edge only", 1, 8'h02);
    writeReg(1, 8'h0A); expectReg("R5 cleared when low", 1, 8'h00);
  endtask

  task automatic testCoincident();
    logic [23:0] s;
    resetDut();
    s = sigIn; s[4] = 1'b1;
    writeSig(0, 8'h10, s);
    expectReg("R8 snapshot taken before edge", 0, 8'h00);
    writeReg(0, 8'h10); expectReg("R8 edge kept", 0, 8'h10);
  endtask

  task automatic testMask();
    resetDut();
    @(negedge clk); sigIn[16] = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 masked irq", {7'd0, irqOut}, 8'h00);
    expectReg("R6 masked summary", 6, 8'h00);
    writeReg(5, 8'h01);
    expectReg("R7 summary on enable", 6, 8'h04);
    check("R9 irq one edge later", {7'd0, irqOut}, 8'h00);
    @(negedge clk);
    check("R6 irq enabled", {7'd0, irqOut}, 8'h01);
    writeReg(6, 8'hFF);
    expectReg("R7 summary ignores write", 6, 8'h04);
    expectReg("R7 enable0 untouched", 3, 8'h00);
    expectReg("R7 enable2 untouched", 5, 8'h01);
    writeReg(5, 8'h00);
    expectReg("R6 summary off", 6, 8'h00);
    @(negedge clk);
    check("R6 irq off", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic testLatency();
    resetDut();
    writeReg(5, 8'h01);
    @(negedge clk); sigIn[16] = 1'b1;
    @(negedge clk);
    expectReg("R9 summary after one edge", 6, 8'h04);
    check("R9 irq not yet", {7'd0, irqOut}, 8'h00);
    @(negedge clk);
    check("R9 irq after two edges", {7'd0, irqOut}, 8'h01);
  endtask

  task automatic testMap();
    resetDut();
    writeReg(3, 8'hA5);
    expectReg("R10 enable readback", 3, 8'hA5);
    writeReg(4, 8'h3C);
    expectReg("R10 enable1 readback", 4, 8'h3C);
    expectReg("R10 enable0 kept", 3, 8'hA5);
    expectReg("R10 unused address", 7, 8'h00);
    expectReg("R10 status untouched", 0, 8'h00);
  endtask

  initial begin
    rst = 1'b1; sigIn = '0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    testReset();
    testEvent();
    testCondition();
    testSelect();
    testDouble();
    testCoincident();
    testMask();
    testLatency();
    testMap();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule